// File: doc/BRIEF.md
# Three-Sample Bang-Bang Phase Decision Unit

This block turns three samples of an incoming serial stream, taken once per bit period, into early/late phase corrections for a clock-recovery loop. Sample A is taken in the middle of the current bit, sample T near the boundary that follows it, and sample B in the middle of the next bit. If A and B match, no edge lay between them and T carries no phase information. If they differ, T shows on which side of the edge the clock sampled: T equal to A means the clock ran ahead, and T equal to B means it lagged.

Each decision gives a registered one-cycle pulse, DOWN for early and UP for late. Alongside the pulse the block emits a signed proportional step of fixed size, which stands for the small phase nudge applied for that one bit. An integral path runs in parallel. It is a signed saturating accumulator that moves by one count for every pulse, so a long run of pulses in one direction steers the centre frequency, while an isolated pulse barely moves it. An external frequency-window monitor drives an enable input. While it reports out-of-window, every correction is suppressed. The retimed data bit is sample A, delayed by one register.

Top module: `edge_vote_pd`

## Requirements
- R1: When A equals B at a clock edge, neither `pulse_up` nor `pulse_dn` is asserted in the following cycle, whatever T is.
- R2: When A equals T and B differs, `pulse_dn` is 1 and `pulse_up` is 0 in the cycle after the edge that samples them.
- R3: When T equals B and A differs, `pulse_up` is 1 and `pulse_dn` is 0 in the cycle after the edge that samples them.
- R4: `data_out` equals the value of `smp_a` sampled at the previous clock edge.
- R5: `pulse_up` and `pulse_dn` are never 1 together, and a single decision followed by a no-edge pattern gives a pulse exactly one cycle long.
- R6: While `freq_ok` is 0 at an edge, no pulse is produced for that edge and `integ_acc` does not change because of it.
- R7: `prop_step` is +STEP while `pulse_up` is 1, -STEP (two's complement) while `pulse_dn` is 1, and 0 otherwise.
- R8: `integ_acc` rises by 1 on the edge after a cycle in which `pulse_up` is 1, and falls by 1 on the edge after a cycle in which `pulse_dn` is 1.
- R9: `integ_acc` saturates at 2^(IW-1)-1 (127 by default) and at -2^(IW-1) (-128 by default) and never wraps.
- R10: `integ_clr` is synchronous and outranks any pulse: after an edge with `integ_clr` = 1, `integ_acc` is 0.
- R11: While `rst_n` is 0, `data_out`, `pulse_up`, `pulse_dn`, `prop_step` and `integ_acc` are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bit-rate clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_a | input | 1 | Sample at the centre of the current bit |
| smp_t | input | 1 | Sample near the following bit boundary |
| smp_b | input | 1 | Sample at the centre of the next bit |
| freq_ok | input | 1 | 1 = oscillator within the frequency window; 0 suppresses corrections |
| integ_clr | input | 1 | Synchronous clear of the integral accumulator |
| data_out | output | 1 | Retimed data (sample A, one cycle later) |
| pulse_up | output | 1 | Late decision: speed the clock up for one bit |
| pulse_dn | output | 1 | Early decision: slow the clock down for one bit |
| prop_step | output | PW | Signed proportional phase step for this bit |
| integ_acc | output | IW | Signed saturating integral of the pulses |

## Verification
The integral clear and a new correction pulse can arrive in the same cycle. So can saturation of the accumulator and a further pulse in the same direction. The bench keeps feeding a late pattern while it raises `integ_clr`, and expects a zero count after that edge despite the live UP pulse. It then pushes well over 128 consecutive late and early decisions and expects the count to stick at +127 and at -128 instead of wrapping. Gating is judged the same way: a late pattern is held while `freq_ok` is low, and both the pulse outputs and the unchanged accumulator are observed.

// File: rtl/evpd_pkg.sv
package evpd_pkg;

  // Outcome of one three-sample vote
  typedef enum logic [1:0] {
    VOTE_NONE  = 2'd0,
    VOTE_LATE  = 2'd1,
    VOTE_EARLY = 2'd2
  } vote_e;

  // A and B equal: no edge, T ignored.
  // Otherwise T agreeing with A means the clock sampled ahead of the edge.
  function automatic vote_e vote3(input logic a, input logic t, input logic b);
    if (a == b)      return VOTE_NONE;
    else if (t == a) return VOTE_EARLY;
    else             return VOTE_LATE;
  endfunction

endpackage

// File: rtl/evpd_decide.sv
module evpd_decide
  import evpd_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  a_i,
  input  logic  t_i,
  input  logic  b_i,
  input  logic  gate_i,
  output vote_e vote_o,
  output logic  up_o,
  output logic  dn_o
);

  vote_e vote_w;
  logic  up_d, dn_d;

  always_comb begin
    vote_w = vote3(a_i, t_i, b_i);
    up_d   = gate_i && (vote_w == VOTE_LATE);
    dn_d   = gate_i && (vote_w == VOTE_EARLY);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      up_o <= 1'b0;
      dn_o <= 1'b0;
    end else begin
      up_o <= up_d;
      dn_o <= dn_d;
    end
  end

  assign vote_o = vote_w;

endmodule

// File: rtl/evpd_retime.sv
module evpd_retime #(
  parameter int DLY = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);

  logic [DLY-1:0] pipe;

  generate
    if (DLY == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe <= '0;
        else        pipe <= d_i;
      end
    end else begin : g_chain
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe <= '0;
        else        pipe <= {pipe[DLY-2:0], d_i};
      end
    end
  endgenerate

  assign q_o = pipe[DLY-1];

endmodule

// File: rtl/evpd_integ.sv
module evpd_integ #(
  parameter int IW = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 clr_i,
  input  logic                 inc_i,
  input  logic                 dec_i,
  output logic signed [IW-1:0] acc_o,
  output logic                 at_max_o,
  output logic                 at_min_o
);

  localparam logic signed [IW-1:0] ACC_MAX = {1'b0, {(IW-1){1'b1}}};
  localparam logic signed [IW-1:0] ACC_MIN = {1'b1, {(IW-1){1'b0}}};

  // One saturating move of the count
  function automatic logic signed [IW-1:0] sat_move(
    input logic signed [IW-1:0] cur,
    input logic up,
    input logic dn
  );
    if (up && cur != ACC_MAX)      return cur + IW'(1);
    else if (dn && cur != ACC_MIN) return cur - IW'(1);
    else                           return cur;
  endfunction

  logic signed [IW-1:0] acc_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     acc_q <= '0;
    else if (clr_i) acc_q <= '0;
    else            acc_q <= sat_move(acc_q, inc_i, dec_i);
  end

  assign acc_o    = acc_q;
  assign at_max_o = (acc_q == ACC_MAX);
  assign at_min_o = (acc_q == ACC_MIN);

endmodule

// File: rtl/edge_vote_pd.sv
module edge_vote_pd
  import evpd_pkg::*;
#(
  parameter int IW   = 8,
  parameter int PW   = 4,
  parameter int STEP = 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          smp_a,
  input  logic          smp_t,
  input  logic          smp_b,
  input  logic          freq_ok,
  input  logic          integ_clr,
  output logic          data_out,
  output logic          pulse_up,
  output logic          pulse_dn,
  output logic [PW-1:0] prop_step,
  output logic [IW-1:0] integ_acc
);

  localparam logic signed [PW-1:0] STEP_POS = PW'(STEP);
  localparam logic signed [PW-1:0] STEP_NEG = -STEP_POS;

  // Named internal events for the checker
  vote_e                vote_now;
  logic                 acc_at_max;
  logic                 acc_at_min;
  logic signed [IW-1:0] acc_w;

  evpd_decide u_decide (
    .clk    (clk),
    .rst_n  (rst_n),
    .a_i    (smp_a),
    .t_i    (smp_t),
    .b_i    (smp_b),
    .gate_i (freq_ok),
    .vote_o (vote_now),
    .up_o   (pulse_up),
    .dn_o   (pulse_dn)
  );

  evpd_retime #(.DLY(1)) u_retime (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   (smp_a),
    .q_o   (data_out)
  );

  evpd_integ #(.IW(IW)) u_integ (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr_i    (integ_clr),
    .inc_i    (pulse_up),
    .dec_i    (pulse_dn),
    .acc_o    (acc_w),
    .at_max_o (acc_at_max),
    .at_min_o (acc_at_min)
  );

  always_comb begin
    if (pulse_up)      prop_step = STEP_POS;
    else if (pulse_dn) prop_step = STEP_NEG;
    else               prop_step = '0;
  end

  assign integ_acc = acc_w;

endmodule

// File: rtl/edge_vote_pd_chk.sv
module edge_vote_pd_chk #(
  parameter int IW   = 8,
  parameter int PW   = 4,
  parameter int STEP = 1
) (
  input logic          clk,
  input logic          rst_n,
  input logic          smp_a,
  input logic          smp_t,
  input logic          smp_b,
  input logic          freq_ok,
  input logic          integ_clr,
  input logic          data_out,
  input logic          pulse_up,
  input logic          pulse_dn,
  input logic [PW-1:0] prop_step,
  input logic [IW-1:0] integ_acc,
  input logic          acc_at_max,
  input logic          acc_at_min
);

  logic armed;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed <= 1'b0;
    else        armed <= 1'b1;
  end

  // R1
  no_edge_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    armed && $past(smp_a) == $past(smp_b) |-> !pulse_up && !pulse_dn);

  // R4
  data_retime_chk: assert property (@(posedge clk) disable iff (!rst_n)
    armed |-> data_out == $past(smp_a));

  // R5
  pulse_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(pulse_up && pulse_dn));

  // R6
  gate_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    armed && !$past(freq_ok) |-> !pulse_up && !pulse_dn);

  // R7
  step_sign_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_up |-> prop_step == PW'(STEP));

  // R9
  no_wrap_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc_at_max && !integ_clr && !pulse_dn |=> $stable(integ_acc));

  // R9
  no_wrap_lo_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc_at_min && !integ_clr && !pulse_up |=> $stable(integ_acc));

  // R10
  clear_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    integ_clr |=> integ_acc == '0);

endmodule

bind edge_vote_pd edge_vote_pd_chk #(.IW(IW), .PW(PW), .STEP(STEP)) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .smp_a      (smp_a),
  .smp_t      (smp_t),
  .smp_b      (smp_b),
  .freq_ok    (freq_ok),
  .integ_clr  (integ_clr),
  .data_out   (data_out),
  .pulse_up   (pulse_up),
  .pulse_dn   (pulse_dn),
  .prop_step  (prop_step),
  .integ_acc  (integ_acc),
  .acc_at_max (acc_at_max),
  .acc_at_min (acc_at_min)
);

// File: tb/edge_vote_pd_test.sv
module edge_vote_pd_test;

  localparam int IW = 8;
  localparam int PW = 4;
  localparam int STEP = 1;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          smp_a = 1'b0, smp_t = 1'b0, smp_b = 1'b0;
  logic          freq_ok = 1'b0, integ_clr = 1'b0;
  logic          data_out, pulse_up, pulse_dn;
  logic [PW-1:0] prop_step;
  logic [IW-1:0] integ_acc;

  int n_run = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  edge_vote_pd #(.IW(IW), .PW(PW), .STEP(STEP)) uut (
    .clk(clk), .rst_n(rst_n), .smp_a(smp_a), .smp_t(smp_t), .smp_b(smp_b),
    .freq_ok(freq_ok), .integ_clr(integ_clr), .data_out(data_out),
    .pulse_up(pulse_up), .pulse_dn(pulse_dn), .prop_step(prop_step),
    .integ_acc(integ_acc)
  );

  // {ok, a, t, b, exp_up, exp_dn, exp_data}
  localparam logic [6:0] VEC [16] = '{
    7'b0_000_000, 7'b0_001_000, 7'b0_010_000, 7'b0_011_000,
    7'b0_100_001, 7'b0_101_001, 7'b0_110_001, 7'b0_111_001,
    7'b1_000_000, 7'b1_001_010, 7'b1_010_000, 7'b1_011_100,
    7'b1_100_101, 7'b1_101_001, 7'b1_110_011, 7'b1_111_001
  };

  task automatic check(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int step_of(input logic up, input logic dn);
    return up ? STEP : (dn ? -STEP : 0);
  endfunction

  task automatic drive(input logic ok, input logic a, input logic t, input logic b);
    freq_ok = ok; smp_a = a; smp_t = t; smp_b = b;
  endtask

  task automatic hold_cycles(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  initial begin : watchdog
    #(4 * 20000);
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_bad);
    $finish;
  end

  initial begin
    // R11: reset state
    hold_cycles(3);
    check("R11 data", data_out, 0);
    check("R11 up", pulse_up, 0);
    check("R11 dn", pulse_dn, 0);
    check("R11 step", $signed(prop_step), 0);
    check("R11 acc", $signed(integ_acc), 0);
    rst_n = 1'b1;
    hold_cycles(1);

    // Vector walk: R1 R2 R3 R4 R6 R7
    for (int i = 0; i < 16; i++) begin
      drive(VEC[i][6], VEC[i][5], VEC[i][4], VEC[i][3]);
      @(negedge clk);
      check("R2/R3/R1/R6 up", pulse_up, VEC[i][2]);
      check("R2/R3/R1/R6 dn", pulse_dn, VEC[i][1]);
      check("R4 data", data_out, VEC[i][0]);
      check("R7 step", $signed(prop_step), step_of(VEC[i][2], VEC[i][1]));
    end

    // R5: single decision gives one-cycle pulse
    drive(1, 0, 0, 0); hold_cycles(3);
    integ_clr = 1'b1; @(negedge clk); integ_clr = 1'b0;
    drive(1, 0, 1, 1); @(negedge clk);
    drive(1, 0, 0, 0);
    check("R5 pulse on", pulse_up, 1);
    @(negedge clk);
    check("R5 pulse off", pulse_up, 0);
    check("R8 one up", $signed(integ_acc), 1);

    // R8: run of downs
    drive(1, 1, 1, 0); hold_cycles(5);
    drive(1, 0, 0, 0); hold_cycles(3);
    check("R8 down run", $signed(integ_acc), -4);

    // R6: gated late pattern leaves acc untouched
    drive(0, 0, 1, 1); hold_cycles(10);
    check("R6 gated up", pulse_up, 0);
    check("R6 gated acc", $signed(integ_acc), -4);

    // R9: saturation both ways
    drive(1, 0, 1, 1); hold_cycles(150);
    check("R9 top", $signed(integ_acc), 127);
    drive(1, 1, 1, 0); hold_cycles(300);
    check("R9 bottom", $signed(integ_acc), -128);

    // R10: clear while pulses keep coming
    drive(1, 0, 1, 1); hold_cycles(4);
    integ_clr = 1'b1; @(negedge clk);
    check("R10 clear", $signed(integ_acc), 0);
    check("R10 pulse live", pulse_up, 1);
    integ_clr = 1'b0;
    drive(1, 0, 0, 0); hold_cycles(3);
    check("R10 resume", $signed(integ_acc), 1);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_bad);
    $finish;
  end

endmodule